// File: doc/BRIEF.md
# Group-Split PWM Audio DAC

This block converts a 10-bit audio sample into a one-bit pulse stream for a voice output path. It does not compare a single ramp against the whole code. Each sample period is cut into 32 groups of 32 time slots. The upper five bits of the sample set how many leading slots are high in every group. The lower five bits set how many groups, counted from the start of the period, carry one further high slot. The average duty over a period is exactly code/1024. The energy sits at the sample rate times 32 instead of at the sample rate itself, which eases the external reconstruction filter. For example, a 10 kHz rate gives a 320 kHz carrier.

A host writes samples through a single 16-bit write port, and only the low ten bits are used. A written sample waits in a holding register and moves into the active register only when a period begins, so a period never mixes two codes. The caller sets the output sample rate by the rate of the slot enable, which must tick 1024 times per sample. For example, 10.24 MHz of ticks gives 10 kHz and 16.384 MHz gives 16 kHz. The reset input is asynchronous and active low, and the block releases it synchronously inside.

Top module: `pwm_group_dac`

## Requirements
- R1: While reset is applied, and after it is released until the first slot tick, `pwm_out` is low. The holding register and the active sample both read as zero.
- R2: Bits 15:10 of `wr_data` are ignored. The output for a written word equals the output for that word with those bits cleared.
- R3: Sample bits [9:5] form the high-value field H and bits [4:0] form the low-value field L.
- R4: A sample period is 1024 `slot_en` ticks: 32 groups g = 0..31 of 32 slots s = 0..31, with slot index = 32*g + s. `pwm_out` changes only on a clock edge at which `slot_en` is high.
- R5: In slot s of group g, `pwm_out` is high exactly when s < H + (g < L ? 1 : 0).
- R6: The number of high slots in every sample period equals the active 10-bit code, 32*H + L.
- R7: A write takes effect at the first slot of the next sample period. A write made in the same cycle as the tick that opens a period takes effect one period later.
- R8: Code 0 gives a constant low output. Code 1023 is high in every slot except slot 31 of group 31.
- R9: The first `slot_en` tick after reset opens the first sample period, and that period uses the sample written before the tick.
- R10: When several writes arrive within one period, only the last one before the period boundary is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the sample register |
| wr_data | input | 16 | Write data; bits 9:0 are the sample |
| slot_en | input | 1 | One-cycle tick per output time slot (1024 per sample) |
| pwm_out | output | 1 | Registered pulse-stream output |

## Verification
The checker assumes that `slot_en` is a single-cycle tick. It also assumes that the period boundary is the tick on which the slot counter wraps, so the active code can change only on that tick and the high-slot count of a whole period can be compared with the code that stayed active for the period. The stimulus drives `slot_en` as isolated one-cycle pulses separated by one or two idle cycles. It places writes mid-period, back to back, and in the same cycle as a boundary tick, so the hand-over between the holding and active registers is covered in every ordering. Each period starts only after the previous one has completed all 1024 ticks, so every whole-period count is checked.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
  localparam int unsigned PGD_BUS_W    = 16;
  localparam int unsigned PGD_SAMPLE_W = 10;

  typedef enum logic [1:0] {
    CMP_LOW   = 2'b00,
    CMP_HIGH  = 2'b01
  } pgd_level_e;
endpackage

// File: rtl/pgd_rst_sync.sv
module pgd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pgd_sample_buf.sv
module pgd_sample_buf #(
  parameter int unsigned SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SAMPLE_W-1:0] wr_code,
  input  logic                load,
  output logic [SAMPLE_W-1:0] pend_o,
  output logic [SAMPLE_W-1:0] active_o,
  output logic [SAMPLE_W-1:0] active_next_o
);
  logic [SAMPLE_W-1:0] pend_q, pend_d;
  logic [SAMPLE_W-1:0] act_q, act_d;

  always_comb begin
    pend_d = wr_en ? wr_code : pend_q;
    act_d  = load  ? pend_q  : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign pend_o        = pend_q;
  assign active_o      = act_q;
  assign active_next_o = act_d;
endmodule

// File: rtl/pgd_slot_counter.sv
module pgd_slot_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_en,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wrap_o = slot_en & (&cnt_q);
    cnt_d  = slot_en ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;
endmodule

// File: rtl/pgd_slot_compare.sv
module pgd_slot_compare #(
  parameter int unsigned HI_W = 5,
  parameter int unsigned LO_W = 5
) (
  input  logic [HI_W+LO_W-1:0] slot_idx,
  input  logic [HI_W+LO_W-1:0] code,
  output logic                 level
);
  logic [LO_W-1:0] group_idx;
  logic [HI_W-1:0] pos_idx;
  logic [HI_W-1:0] hi_val;
  logic [LO_W-1:0] lo_val;
  logic [HI_W:0]   limit;

  always_comb begin
    group_idx = slot_idx[HI_W+LO_W-1:HI_W];
    pos_idx   = slot_idx[HI_W-1:0];
    hi_val    = code[HI_W+LO_W-1:LO_W];
    lo_val    = code[LO_W-1:0];
    limit     = {1'b0, hi_val} + {{HI_W{1'b0}}, (group_idx < lo_val)};
    level     = ({1'b0, pos_idx} < limit);
  end
endmodule

// File: rtl/pwm_group_dac.sv
module pwm_group_dac #(
  parameter int unsigned BUS_W    = pgd_pkg::PGD_BUS_W,
  parameter int unsigned SAMPLE_W = pgd_pkg::PGD_SAMPLE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             slot_en,
  output logic             pwm_out
);
  localparam int unsigned LO_W = SAMPLE_W / 2;
  localparam int unsigned HI_W = SAMPLE_W - LO_W;

  logic                rst_n_sync;
  logic [SAMPLE_W-1:0] cnt, cnt_next;
  logic                wrap;
  logic [SAMPLE_W-1:0] pend, active, active_next;
  logic                level_next;
  logic                pwm_q, pwm_d;

  pgd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pgd_slot_counter #(.CNT_W(SAMPLE_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .slot_en    (slot_en),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next),
    .wrap_o     (wrap)
  );

  pgd_sample_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .wr_en         (wr_en),
    .wr_code       (wr_data[SAMPLE_W-1:0]),
    .load          (wrap),
    .pend_o        (pend),
    .active_o      (active),
    .active_next_o (active_next)
  );

  pgd_slot_compare #(.HI_W(HI_W), .LO_W(LO_W)) u_cmp (
    .slot_idx (cnt_next),
    .code     (active_next),
    .level    (level_next)
  );

  always_comb begin
    pwm_d = slot_en ? level_next : pwm_q;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) pwm_q <= 1'b0;
    else             pwm_q <= pwm_d;
  end

  assign pwm_out = pwm_q;
endmodule

// File: rtl/pgd_checker.sv
module pgd_checker #(
  parameter int unsigned SAMPLE_W = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                slot_en,
  input logic [SAMPLE_W-1:0] cnt,
  input logic [SAMPLE_W-1:0] pend,
  input logic [SAMPLE_W-1:0] active,
  input logic                pwm_out
);
  logic [SAMPLE_W:0] acc_q;
  logic              started_q;
  logic [SAMPLE_W:0] total;
  logic              at_end;

  assign at_end = slot_en & (&cnt);
  assign total  = acc_q + {{SAMPLE_W{1'b0}}, pwm_out};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      started_q <= 1'b0;
    end else if (slot_en) begin
      if (&cnt) begin
        acc_q     <= '0;
        started_q <= 1'b1;
      end else begin
        acc_q <= total;
      end
    end
  end

  assert_out_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> $stable(pwm_out));

  assert_slot_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_en |=> cnt == SAMPLE_W'($past(cnt) + 1'b1));

  assert_active_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !at_end |=> $stable(active));

  assert_boundary_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> active == $past(pend));

  assert_zero_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> !pwm_out);

  assert_period_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && started_q) |-> total == {1'b0, active});
endmodule

bind pwm_group_dac pgd_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_sync),
  .slot_en (slot_en),
  .cnt     (cnt),
  .pend    (pend),
  .active  (active),
  .pwm_out (pwm_out)
);

// File: tb/tb_pwm_group_dac.sv
module tb_pwm_group_dac;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        slot_en;
  logic        pwm_out;

  pwm_group_dac dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .slot_en (slot_en),
    .pwm_out (pwm_out)
  );

  typedef struct {
    logic  exp;
    logic  last;
    int    code;
    string tag;
  } item_t;

  item_t q[$];
  int    checks;
  int    fails;
  int    cycles;
  int    obs_high;
  logic  sl_d;
  logic  done;
  string cur_tag;
  int    m_cnt;
  int    m_pend;
  int    m_act;
  int    gap_sel;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) sl_d <= slot_en;

  // monitor: pop and compare one expected bit per slot tick
  always @(negedge clk) begin
    if (rst_n && sl_d && !done) begin
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R4: slot tick with no expected item, got %0b expected none", pwm_out);
      end else begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (pwm_out !== it.exp) begin
          fails++;
          $display("FAIL %s: code %0h got %0b expected %0b", it.tag, it.code, pwm_out, it.exp);
        end
        obs_high += (pwm_out === 1'b1) ? 1 : 0;
        if (it.last) begin
          checks++;
          if (obs_high != it.code) begin
            fails++;
            $display("FAIL R6: high slots %0d expected %0d", obs_high, it.code);
          end
          obs_high = 0;
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: cycles %0d expected below 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // driver: one cycle of stimulus, model updated from the requirements
  task automatic step(input logic do_slot, input logic do_wr, input logic [15:0] d);
    @(negedge clk);
    slot_en = do_slot;
    wr_en   = do_wr;
    wr_data = d;
    if (do_slot) begin
      item_t it;
      int g, s, hv, lv;
      if (m_cnt == 1023) begin
        m_act = m_pend;      // R7/R9: boundary uses the value held before this cycle
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
      g  = m_cnt / 32;
      s  = m_cnt % 32;
      hv = m_act / 32;       // R3 field split
      lv = m_act % 32;
      it.exp  = (s < hv + ((g < lv) ? 1 : 0)) ? 1'b1 : 1'b0;  // R5
      it.last = (m_cnt == 1023) ? 1'b1 : 1'b0;
      it.code = m_act;
      it.tag  = cur_tag;
      q.push_back(it);
    end
    if (do_wr) m_pend = int'(d[9:0]);   // R2: upper bits dropped
    @(negedge clk);
    slot_en = 1'b0;
    wr_en   = 1'b0;
    wr_data = 16'h0000;
    gap_sel++;
    if (gap_sel % 3 == 0) @(negedge clk);
  endtask

  task automatic slots(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 16'h0000);
  endtask

  task automatic to_end();
    while (m_cnt != 1023) step(1'b1, 1'b0, 16'h0000);
  endtask

  initial begin
    done     = 1'b0;
    checks   = 0;
    fails    = 0;
    cycles   = 0;
    obs_high = 0;
    gap_sel  = 0;
    m_cnt    = 1023;
    m_pend   = 0;
    m_act    = 0;
    cur_tag  = "R1";
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    wr_data  = 16'h0000;
    slot_en  = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (pwm_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: pwm_out during reset %0b expected 0", pwm_out);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (pwm_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: pwm_out after reset %0b expected 0", pwm_out);
    end

    // R9: sample written before the first tick, no ticks yet
    step(1'b0, 1'b1, 16'h02A5);
    repeat (5) @(negedge clk);
    checks++;
    if (pwm_out !== 1'b0) begin
      fails++;
      $display("FAIL R4: pwm_out without slot ticks %0b expected 0", pwm_out);
    end

    cur_tag = "R9";
    slots(300);
    cur_tag = "R7";
    step(1'b0, 1'b1, 16'h03FF);   // mid-period write: current period keeps 0x2A5
    to_end();

    cur_tag = "R8";               // full-scale period
    slots(10);
    step(1'b0, 1'b1, 16'hFC00);   // code 0 with upper bits set
    to_end();

    cur_tag = "R2";               // must be constant low
    slots(500);
    step(1'b0, 1'b1, 16'hFC1F);   // H=0, L=31
    to_end();

    cur_tag = "R3";
    slots(5);
    step(1'b0, 1'b1, 16'h03E0);   // H=31, L=0
    to_end();

    cur_tag = "R3";
    slots(40);
    step(1'b0, 1'b1, 16'h0001);
    to_end();

    cur_tag = "R7";               // write in the boundary cycle: period uses 0x001
    step(1'b1, 1'b1, 16'h0155);
    to_end();

    cur_tag = "R7";               // now 0x155
    slots(20);
    step(1'b0, 1'b1, 16'h0100);
    step(1'b0, 1'b1, 16'h00C3);
    to_end();

    cur_tag = "R10";              // last write wins: 0x0C3
    slots(1);
    to_end();

    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R4: %0d expected items left, expected 0", q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule